// File: doc/BRIEF.md
# UART Nine-Bit Character Register Interface

This block is the byte-wide register front end that software uses to move characters through a UART. The UART can run 8-bit or 9-bit characters. One bus address, the data address, carries both directions. A read there returns the received byte. A write there hands a byte to the transmitter through a separate transmit register that software cannot read back. A second bus address, the control address, carries the ninth bit in each direction.

A 9-bit transmit character takes two byte writes. Software first writes the ninth bit to the control address, and the block keeps that value in a staging register. Software then writes the low byte to the data address. That second write moves the staged bit into the live transmit-ninth-bit field and issues the full character on the transmit port in the same step. On the receive side, the ninth bit of the character in the holding register is shown at the control address. A read of the data address pops that character, so software reads the control address first. In 8-bit mode with parity enabled, a character holds seven data bits plus a parity bit in bit 7. The block generates that parity bit for transmit and passes the received parity bit through for receive.

The transmit port is valid/ready. `tx_valid` stays high, and `tx_char` stays stable, until the cycle in which `tx_ready` is high. A new data write is accepted when the slot is empty, or when the slot is being drained in that same cycle. Otherwise the write is dropped and a sticky overrun flag is raised. The receive port is also valid/ready. `rx_ready` is high only while the receive holding register is empty, and a character is taken in a cycle where `rx_valid` and `rx_ready` are both high.

Top module: `uart_char_regs`

## Requirements
- R1: After reset, the data address reads 0x00 and the control address reads 0x00. `tx_valid` is 0, `tx_char` is 0, `rx_ready` is 1 and `tx_overrun` is 0.
- R2: A write to the control address (address 1) stores bit 6 of the write data in a staging register only. The live transmit-ninth-bit field (control readback bit 6) does not change, and nothing is sent.
- R3: An accepted write to the data address (address 0) in 9-bit mode sends `tx_char = {staged bit, byte}` with `tx_valid` high from the next cycle. The same write copies the staged bit into control readback bit 6.
- R4: A data write with no control write before it uses the staged ninth bit left by the most recent control write.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_char` stays stable. A data write in a cycle where `tx_ready` is high is accepted at once.
- R6: A data write while `tx_valid` is high and `tx_ready` is low is dropped. `tx_char` and control bit 6 stay unchanged, and `tx_overrun` goes to 1 and stays at 1 until reset.
- R7: A character is captured when `rx_valid` and `rx_ready` are both high. `rx_ready` is then low until the character is popped, and characters offered meanwhile are ignored. The data address reads bits 7:0 of the captured character. In 9-bit mode, control readback bit 7 shows its bit 8.
- R8: A bus read of the data address pops the character, and `rx_ready` is 1 in the next cycle. The data byte and control bit 7 hold their values until the next character is captured.
- R9: In 8-bit mode (`fmt_nine` = 0), bit 8 of `tx_char` is 0 whatever the staged bit is, and control readback bit 7 reads 0 for a captured character.
- R10: In 8-bit mode with `parity_en` = 1, transmit bit 7 is replaced by the even parity of write-data bits 6:0. A received character returns its parity bit unchanged in bit 7 of the data address.
- R11: In 9-bit mode, `parity_en` has no effect, and all eight written bits plus the staged bit are sent as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_addr | input | 1 | 0 = data address, 1 = control address |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (pops on the data address) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| fmt_nine | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| parity_en | input | 1 | Parity enable in 8-bit mode |
| tx_valid | output | 1 | Transmit character valid |
| tx_ready | input | 1 | Transmitter accepts the character |
| tx_char | output | 9 | Transmit character |
| rx_valid | input | 1 | Received character offered |
| rx_ready | output | 1 | Receive holding register empty |
| rx_char | input | 9 | Received character |
| tx_overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with its default parameters. The transmit ninth bit sits at control bit 6, the receive ninth bit at control bit 7, and parity is even. With these values, every vector can compute its expected character from a fixed bit map and a plain XOR over seven bits. A walked vector table runs a chain of staged-bit writes and skipped writes, so the stale-value behaviour of the staging register shows up across mode and parity changes. Directed sequences then hold the transmit port stalled to drive the accept-while-draining and overrun cases. They also hold `rx_valid` high across a full holding register and a pop, so the capture, the ignored offer and the stability of the ninth bit are all visible at the ports.

// File: rtl/uart_char_pkg.sv
package uart_char_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAR_W = BYTE_W + 1;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              ninth;
    logic [BYTE_W-1:0] low;
  } char_t;
endpackage

// File: rtl/uart_t8_stage.sv
module uart_t8_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic ctrl_bit,
  input  logic commit,
  output logic staged,
  output logic live
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= 1'b0;
      live   <= 1'b0;
    end else begin
      if (wr_ctrl) staged <= ctrl_bit;
      if (commit)  live   <= staged;
    end
  end

  assert_ctrl_only_stages_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !commit) |=> $stable(live));

  assert_commit_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_ctrl) |=> (live == $past(staged)));
endmodule

// File: rtl/uart_tx_slot.sv
module uart_tx_slot
  import uart_char_pkg::*;
#(
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ninth_in,
  input  logic              fmt_nine,
  input  logic              parity_en,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  output logic              overrun,
  output logic              accept
);
  localparam int PAR_POS = BYTE_W - 1;

  char_t next_char;

  assign accept = wr_data && (!tx_valid || tx_ready);

  always_comb begin
    next_char.low   = wbyte;
    next_char.ninth = fmt_nine ? ninth_in : 1'b0;
    if (!fmt_nine && parity_en)
      next_char.low[PAR_POS] = (^wbyte[PAR_POS-1:0]) ^ PARITY_ODD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_char  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (accept) begin
        tx_valid <= 1'b1;
        tx_char  <= next_char;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (wr_data && !accept) overrun <= 1'b1;
    end
  end

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_char)));

  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_valid && !tx_ready) |=> (overrun && $stable(tx_char)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_eight_bit_ninth_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !fmt_nine && !tx_valid) |=> !tx_char[CHAR_W-1]);
endmodule

// File: rtl/uart_rx_slot.sv
module uart_rx_slot
  import uart_char_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              fmt_nine,
  input  logic              pop,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ninth
);
  logic full;
  logic take;

  assign rx_ready = !full;
  assign take     = rx_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      rx_byte  <= '0;
      rx_ninth <= 1'b0;
    end else begin
      if (take) begin
        full     <= 1'b1;
        rx_byte  <= rx_char[BYTE_W-1:0];
        rx_ninth <= fmt_nine & rx_char[CHAR_W-1];
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  assert_capture_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  assert_pop_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && pop) |=> rx_ready);

  assert_holds_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ready) |=> ($stable(rx_byte) && $stable(rx_ninth)));
endmodule

// File: rtl/uart_char_regs.sv
module uart_char_regs
  import uart_char_pkg::*;
#(
  parameter int T8_POS     = 6,
  parameter int R8_POS     = 7,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              fmt_nine,
  input  logic              parity_en,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              tx_overrun
);
  reg_sel_e          sel;
  logic              wr_data, wr_ctrl, pop;
  logic              staged, live, accept;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_ninth;
  logic [BYTE_W-1:0] ctrl_view;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_data = bus_sel && bus_wr && (sel == SEL_DATA);
  assign wr_ctrl = bus_sel && bus_wr && (sel == SEL_CTRL);
  assign pop     = bus_sel && bus_rd && (sel == SEL_DATA);

  uart_t8_stage u_t8 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .ctrl_bit (bus_wdata[T8_POS]),
    .commit   (accept),
    .staged   (staged),
    .live     (live)
  );

  uart_tx_slot #(.PARITY_ODD(PARITY_ODD)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wbyte     (bus_wdata),
    .ninth_in  (staged),
    .fmt_nine  (fmt_nine),
    .parity_en (parity_en),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_char   (tx_char),
    .overrun   (tx_overrun),
    .accept    (accept)
  );

  uart_rx_slot u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .fmt_nine (fmt_nine),
    .pop      (pop),
    .rx_ready (rx_ready),
    .rx_byte  (rx_byte),
    .rx_ninth (rx_ninth)
  );

  for (genvar b = 0; b < BYTE_W; b++) begin : g_ctrl_view
    if (b == T8_POS)      begin : g_t8   assign ctrl_view[b] = live;     end
    else if (b == R8_POS) begin : g_r8   assign ctrl_view[b] = rx_ninth; end
    else                  begin : g_zero assign ctrl_view[b] = 1'b0;     end
  end

  assign bus_rdata = (sel == SEL_DATA) ? rx_byte : ctrl_view;

  initial assert (T8_POS != R8_POS && T8_POS < BYTE_W && R8_POS < BYTE_W);

  assert_dropped_write_keeps_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_valid && !tx_ready) |=> $stable(live));
endmodule

// File: tb/uart_char_regs_tb.sv
`timescale 1ns/1ps
module uart_char_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_addr = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fmt_nine = 0, parity_en = 0;
  logic       tx_valid, tx_ready = 0;
  logic [8:0] tx_char;
  logic       rx_valid = 0, rx_ready;
  logic [8:0] rx_char = '0;
  logic       tx_overrun;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  logic [7:0] rd;
  logic       hold;

  always #10 clk = ~clk;

  uart_char_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fmt_nine(fmt_nine), .parity_en(parity_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_char(tx_char), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_char(rx_char), .tx_overrun(tx_overrun)
  );

  typedef struct packed {
    logic       m9;
    logic       pe;
    logic       do_t8;
    logic       t8;
    logic [7:0] b;
    logic [8:0] exp;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 9'h1A5},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 9'h13C},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 9'h0FF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 9'h000},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h81, 9'h081},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h83, 9'h003},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h07, 9'h087},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h7F, 9'h0FF},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 9'h103},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 9'h080}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(1'b0, rd); check(rd == 8'h00, "R1", "data reads", rd, 0);
    peek(1'b1, rd); check(rd == 8'h00, "R1", "ctrl reads", rd, 0);
    check(tx_valid == 0 && tx_char == 0, "R1", "tx idle", {tx_valid, tx_char}, 0);
    check(rx_ready == 1 && tx_overrun == 0, "R1", "ready/overrun",
          {rx_ready, tx_overrun}, 2);

    // Table walk: R3 R4 R9 R10 R11
    hold = 0;
    for (int i = 0; i < 10; i++) begin
      fmt_nine = VEC[i].m9; parity_en = VEC[i].pe;
      if (VEC[i].do_t8) begin
        bus_write(1'b1, {1'b0, VEC[i].t8, 6'b0});
        hold = VEC[i].t8;
      end
      bus_write(1'b0, VEC[i].b);
      check(tx_valid == 1 && tx_char == VEC[i].exp, "R3/R4/R9/R10/R11",
            $sformatf("vector %0d tx_char", i), tx_char, VEC[i].exp);
      peek(1'b1, rd);
      check(rd[6] == hold, "R3", $sformatf("vector %0d live ninth", i), rd[6], hold);
      tx_ready = 1; @(negedge clk); tx_ready = 0;
      check(tx_valid == 0, "R5", $sformatf("vector %0d drained", i), tx_valid, 0);
    end

    // R2: control write stages only
    fmt_nine = 1; parity_en = 0;
    bus_write(1'b1, 8'h40);
    peek(1'b1, rd); check(rd[6] == 1'b0, "R2", "live unchanged", rd[6], 0);
    check(tx_valid == 0, "R2", "nothing sent", tx_valid, 0);
    bus_write(1'b0, 8'h11);
    check(tx_char == 9'h111, "R3", "staged bit used", tx_char, 9'h111);
    peek(1'b1, rd); check(rd[6] == 1'b1, "R3", "live committed", rd[6], 1);

    // R5 stall then accept-while-draining
    repeat (3) @(negedge clk);
    check(tx_valid == 1 && tx_char == 9'h111, "R5", "held under stall", tx_char, 9'h111);
    tx_ready = 1;
    bus_write(1'b0, 8'h22);
    tx_ready = 0;
    check(tx_valid == 1 && tx_char == 9'h122, "R5", "accept on drain", tx_char, 9'h122);
    check(tx_overrun == 0, "R5", "no overrun", tx_overrun, 0);

    // R6 overrun
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h33);
    check(tx_char == 9'h122, "R6", "char unchanged", tx_char, 9'h122);
    check(tx_overrun == 1, "R6", "overrun set", tx_overrun, 1);
    peek(1'b1, rd); check(rd[6] == 1'b1, "R6", "live unchanged", rd[6], 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    @(negedge clk);
    check(tx_overrun == 1 && tx_valid == 0, "R6", "sticky after drain",
          {tx_overrun, tx_valid}, 2);

    // R7 / R8 receive
    rx_valid = 1; rx_char = 9'h15A;
    @(negedge clk);
    rx_char = 9'h033;
    check(rx_ready == 0, "R7", "full blocks", rx_ready, 0);
    peek(1'b0, rd); check(rd == 8'h5A, "R7", "data byte", rd, 8'h5A);
    peek(1'b1, rd); check(rd[7] == 1'b1, "R7", "ninth bit", rd[7], 1);
    @(negedge clk);
    peek(1'b0, rd); check(rd == 8'h5A, "R7", "offer ignored while full", rd, 8'h5A);
    bus_read(1'b0, rd);
    check(rd == 8'h5A, "R8", "pop returns byte", rd, 8'h5A);
    check(rx_ready == 1, "R8", "ready after pop", rx_ready, 1);
    peek(1'b1, rd); check(rd[7] == 1'b1, "R8", "ninth stable after pop", rd[7], 1);
    @(negedge clk);
    rx_valid = 0;
    peek(1'b0, rd); check(rd == 8'h33, "R8", "next byte", rd, 8'h33);
    peek(1'b1, rd); check(rd[7] == 1'b0, "R8", "next ninth", rd[7], 0);

    // R9 receive in 8-bit mode
    fmt_nine = 0;
    bus_read(1'b0, rd);
    rx_valid = 1; rx_char = 9'h144;
    @(negedge clk); rx_valid = 0;
    peek(1'b0, rd); check(rd == 8'h44, "R9", "8-bit byte", rd, 8'h44);
    peek(1'b1, rd); check(rd[7] == 1'b0, "R9", "ninth reads 0", rd[7], 0);

    // R10 receive parity bit passes through
    parity_en = 1;
    bus_read(1'b0, rd);
    rx_valid = 1; rx_char = 9'h0C1;
    @(negedge clk); rx_valid = 0;
    peek(1'b0, rd); check(rd == 8'hC1, "R10", "parity bit in bit 7", rd, 8'hC1);

    done = 1;
    summary();
    $finish;
  end
endmodule